// File: doc/BRIEF.md
# External Bus Idle Cycle Inserter

This block sequences bus cycles on an external memory bus. A requester hands it one access at a time. Each access carries a read/write flag, a 3-bit area number, a length flag that selects 2 or 3 states, and an address. For each access the sequencer steps the bus-state output through T1, T2 and, for long accesses, T3. During those states it drives the read or write strobe and holds the address.

Some devices, such as slow ROMs, take a long time to release the data bus after a read. To protect against them, the sequencer can put a single idle state (Ti) in front of a cycle. It does this in two cases, each with its own enable bit:
- a read that follows a read to a different area;
- a write that follows a read.

Both enables come out of reset set. Either can be cleared through a small write port. The type and area of the last accepted access are kept in registers, so the comparison still works after the bus has sat unused.

The state machine has five states:

| State | Meaning |
|-------|---------|
| NONE | bus free |
| TI | idle state inserted ahead of a cycle |
| T1, T2, T3 | states of a bus cycle |

It has these transitions:
- NONE→TI or NONE→T1 when a request is accepted;
- TI→T1 always;
- T1→T2 always;
- T2→T3 for a 3-state access;
- from the final state (T2 of a short access, or T3) back to NONE, TI or T1, depending on whether a new request is accepted and whether an idle state is needed.

Top module: `bus_idle_seq`

## Requirements
- R1: After reset, `bus_state` is NONE (code 0), both strobes and `cyc_done` are low, `req_ready` is high, and both enables are set.
- R2: With the read-after-read enable set (`cfg_wdata` bit 1), a read accepted after a read to a different area is preceded by exactly one Ti state (code 4), directly before its T1 (code 1).
- R3: With the write-after-read enable set (`cfg_wdata` bit 0), a write accepted after a read is preceded by exactly one Ti state.
- R4: Clearing an enable bit removes the idle state for its case only. The other case keeps its behaviour.
- R5: A read after a read to the same area never gets an idle state. Neither does any access that follows a write.
- R6: A 3-state access shows T1, T2, T3 (codes 1, 2, 3). A 2-state access shows T1, T2. `cyc_done` is high on the final T state only.
- R7: `rd_strb` is high exactly in the T states of a read, and `wr_strb` is high exactly in the T states of a write. Both are low during Ti and NONE.
- R8: `req_ready` is high when no cycle is running or during a final T state. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, which allows back-to-back cycles.
- R9: The previous access is remembered across any number of unused cycles. The first access after reset never gets an idle state.
- R10: A configuration write takes effect for decisions made at later edges. A request accepted on the same edge as the write uses the old settings.
- R11: `bus_addr` shows the accepted address and stays constant from T1 through the final T state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_area | input | 3 | area number of the request |
| req_long | input | 1 | 1 = 3-state access, 0 = 2-state access |
| req_addr | input | 24 | request address |
| cfg_we | input | 1 | enable register write strobe |
| cfg_wdata | input | 2 | bit 1 = read-after-read enable, bit 0 = write-after-read enable |
| bus_state | output | 3 | 0 NONE, 1 T1, 2 T2, 3 T3, 4 Ti |
| rd_strb | output | 1 | read strobe |
| wr_strb | output | 1 | write strobe |
| bus_addr | output | 24 | address bus |
| cyc_done | output | 1 | final T state of a cycle |

## Verification
The hardest case to reach from the ports is a configuration write that lands on the same clock edge as a request acceptance. The bench creates it by driving `cfg_we` and `req_valid` together while the bus is free, so that both take effect at the same edge. A second hard case is the remembered previous access after the bus has been idle. The bench reaches it by leaving several empty cycles between a read and a read to another area. A behavioural queue model predicts state, strobes, address, completion and ready on every clock.

// File: rtl/bis_pkg.sv
package bis_pkg;
    typedef enum logic [2:0] {
        BS_NONE = 3'd0,
        BS_T1   = 3'd1,
        BS_T2   = 3'd2,
        BS_T3   = 3'd3,
        BS_TI   = 3'd4
    } bus_st_e;
endpackage

// File: rtl/bis_cfg_reg.sv
module bis_cfg_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] wdata,
    output logic       en_rr,
    output logic       en_war
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_rr  <= 1'b1;
            en_war <= 1'b1;
        end else if (we) begin
            en_rr  <= wdata[1];
            en_war <= wdata[0];
        end
    end
endmodule

// File: rtl/bis_idle_policy.sv
module bis_idle_policy #(
    parameter int AREA_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              nxt_write,
    input  logic [AREA_W-1:0] nxt_area,
    input  logic              en_rr,
    input  logic              en_war,
    output logic              insert_idle
);
    logic              have_prev;
    logic              prev_write;
    logic [AREA_W-1:0] prev_area;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_prev  <= 1'b0;
            prev_write <= 1'b0;
            prev_area  <= '0;
        end else if (accept) begin
            have_prev  <= 1'b1;
            prev_write <= nxt_write;
            prev_area  <= nxt_area;
        end
    end

    always_comb begin
        insert_idle = 1'b0;
        if (have_prev && !prev_write) begin
            if (nxt_write)
                insert_idle = en_war;
            else
                insert_idle = en_rr && (nxt_area != prev_area);
        end
    end

    // R5: no idle state after a write or before the first access
    a_r5_no_idle_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        insert_idle |-> (have_prev && !prev_write));
endmodule

// File: rtl/bus_idle_seq.sv
module bus_idle_seq #(
    parameter int ADDR_W = 24,
    parameter int AREA_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AREA_W-1:0] req_area,
    input  logic              req_long,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_wdata,
    output logic [2:0]        bus_state,
    output logic              rd_strb,
    output logic              wr_strb,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              cyc_done
);
    import bis_pkg::*;

    bus_st_e           st_q, st_d;
    logic              cur_write, cur_long;
    logic [ADDR_W-1:0] addr_q;
    logic              en_rr, en_war, insert_idle;
    logic              final_st, accept, in_t;

    bis_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .en_rr  (en_rr),
        .en_war (en_war)
    );

    bis_idle_policy #(.AREA_W(AREA_W)) u_pol (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .nxt_write   (req_write),
        .nxt_area    (req_area),
        .en_rr       (en_rr),
        .en_war      (en_war),
        .insert_idle (insert_idle)
    );

    assign final_st  = (st_q == BS_T3) || (st_q == BS_T2 && !cur_long);
    assign req_ready = (st_q == BS_NONE) || final_st;
    assign accept    = req_valid && req_ready;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BS_NONE: if (accept) st_d = insert_idle ? BS_TI : BS_T1;
            BS_TI:   st_d = BS_T1;
            BS_T1:   st_d = BS_T2;
            BS_T2: begin
                if (cur_long)    st_d = BS_T3;
                else if (accept) st_d = insert_idle ? BS_TI : BS_T1;
                else             st_d = BS_NONE;
            end
            BS_T3: begin
                if (accept) st_d = insert_idle ? BS_TI : BS_T1;
                else        st_d = BS_NONE;
            end
            default: st_d = BS_NONE;
        endcase
    end

    // state register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= BS_NONE;
            cur_write <= 1'b0;
            cur_long  <= 1'b0;
            addr_q    <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                cur_write <= req_write;
                cur_long  <= req_long;
                addr_q    <= req_addr;
            end
        end
    end

    // outputs
    always_comb begin
        in_t      = (st_q == BS_T1) || (st_q == BS_T2) || (st_q == BS_T3);
        bus_state = st_q;
        rd_strb   = in_t && !cur_write;
        wr_strb   = in_t && cur_write;
        bus_addr  = addr_q;
        cyc_done  = final_st;
    end

    a_r7_no_strobe_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BS_TI || st_q == BS_NONE) |-> (!rd_strb && !wr_strb));
    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_strb, wr_strb}) <= 1);
    a_r2_idle_then_t1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BS_TI) |=> (st_q == BS_T1));
    a_r6_t3_after_t2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BS_T3) |-> ($past(st_q) == BS_T2));
    a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BS_T2 || st_q == BS_T3) |-> $stable(bus_addr));
    a_r8_ready_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && st_q != BS_NONE) |-> cyc_done);
endmodule

// File: tb/bus_idle_seq_test.sv
`timescale 1ns/1ps
module bus_idle_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_long = 1'b0;
    logic [2:0]  req_area = '0;
    logic [23:0] req_addr = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_wdata = '0;
    logic        req_ready, rd_strb, wr_strb, cyc_done;
    logic [2:0]  bus_state;
    logic [23:0] bus_addr;

    always #2 clk = ~clk;

    bus_idle_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_area(req_area), .req_long(req_long),
        .req_addr(req_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .bus_state(bus_state), .rd_strb(rd_strb), .wr_strb(wr_strb),
        .bus_addr(bus_addr), .cyc_done(cyc_done)
    );

    typedef struct {
        int          st;
        bit          rd;
        bit          wr;
        bit          dn;
        logic [23:0] ad;
    } exp_t;

    exp_t  q[$];
    int    checks = 0, fails = 0;
    string tag = "R1";
    bit    m_en_rr = 1, m_en_war = 1, m_have = 0, m_pw = 0;
    int    m_pa = 0;

    // behavioural model: queue of expected bus states
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_en_rr = 1; m_en_war = 1; m_have = 0;
        end else begin
            bit mready, ins;
            exp_t e;
            mready = (q.size() <= 1);
            if (q.size() > 0) void'(q.pop_front());
            if (req_valid && mready) begin
                ins = m_have && !m_pw &&
                      ((req_write && m_en_war) ||
                       (!req_write && m_en_rr && int'(req_area) != m_pa));
                if (ins) begin
                    e.st = 4; e.rd = 0; e.wr = 0; e.dn = 0; e.ad = req_addr;
                    q.push_back(e);
                end
                for (int k = 1; k <= (req_long ? 3 : 2); k++) begin
                    e.st = k; e.rd = !req_write; e.wr = req_write;
                    e.dn = (k == (req_long ? 3 : 2)); e.ad = req_addr;
                    q.push_back(e);
                end
                m_have = 1; m_pw = req_write; m_pa = int'(req_area);
            end
            if (cfg_we) begin
                m_en_rr = cfg_wdata[1]; m_en_war = cfg_wdata[0];
            end
        end
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            exp_t e;
            if (q.size() > 0) e = q[0];
            else begin e.st = 0; e.rd = 0; e.wr = 0; e.dn = 0; e.ad = '0; end
            chk("bus_state", int'(bus_state), e.st);
            chk("rd_strb", int'(rd_strb), int'(e.rd));
            chk("wr_strb", int'(wr_strb), int'(e.wr));
            chk("cyc_done", int'(cyc_done), int'(e.dn));
            chk("req_ready", int'(req_ready), int'(q.size() <= 1));
            if (e.st >= 1 && e.st <= 3) chk("bus_addr (R11)", int'(bus_addr), int'(e.ad));
        end
    end

    task automatic issue(string t, bit w, int area, bit lng, int addr);
        tag = t;
        req_valid = 1; req_write = w; req_area = area[2:0];
        req_long = lng; req_addr = addr[23:0];
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic cfg(bit [1:0] v);
        cfg_we = 1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    bit finished = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tag = "R1";
        idle(3);
        // R9: first access after reset, no idle state
        issue("R9", 0, 0, 1, 24'h000100);
        issue("R5", 0, 0, 0, 24'h000104);   // same-area read, back to back (R8)
        issue("R2", 0, 2, 1, 24'h400000);   // read, different area
        issue("R3", 1, 2, 0, 24'h400010);   // write after read
        issue("R5", 1, 3, 1, 24'h600000);   // write after write
        issue("R5", 0, 5, 0, 24'hA00000);   // read after write
        tag = "R9"; idle(6);
        issue("R9", 0, 1, 0, 24'h200000);   // different area after gap
        idle(4);
        issue("R6", 0, 1, 1, 24'h200020);   // 3-state read, R7 strobes
        issue("R6", 1, 1, 0, 24'h200030);   // 2-state write
        idle(2);
        cfg(2'b00);
        issue("R4", 0, 3, 0, 24'h600040);
        issue("R4", 0, 4, 0, 24'h800040);
        issue("R4", 1, 4, 1, 24'h800050);
        cfg(2'b01);
        issue("R4", 0, 6, 0, 24'hC00000);
        issue("R4", 0, 7, 1, 24'hE00000);
        issue("R4", 1, 7, 0, 24'hE00004);
        cfg(2'b10);
        issue("R4", 0, 0, 0, 24'h000200);
        issue("R4", 1, 0, 0, 24'h000204);
        issue("R4", 0, 2, 0, 24'h400200);
        issue("R4", 0, 3, 1, 24'h600200);
        idle(3);
        cfg(2'b00);
        issue("R10", 0, 1, 0, 24'h200100);
        idle(3);
        // same-edge config write and acceptance: old settings apply
        cfg_we = 1; cfg_wdata = 2'b11;
        issue("R10", 0, 4, 0, 24'h800100);
        cfg_we = 0;
        idle(1);
        issue("R10", 0, 6, 1, 24'hC00100);
        issue("R10", 1, 6, 0, 24'hC00104);
        tag = "R8"; idle(4);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule